// File: doc/BRIEF.md
# Grouped GPIO Pin Interrupt Controller

This block watches the pins of two 32-bit GPIO ports and folds any chosen subset of them into a single interrupt request. Each pin has two configuration bits. One bit includes or excludes the pin. The other bit chooses whether the pin counts as active when it is high or when it is low. The selected pins are merged in one of two ways: the group condition is true when any selected pin is active, or only when all of them are active. The merged condition can latch the interrupt on its rising edge or on its level.

Software reaches the block through a plain 32-bit register bus made of a byte address, a write strobe, write data and combinational read data. It reads the latched status and the mode bits in the control word, and it clears the status by writing a one. Pin inputs pass through a two-flop synchronizer before polarity and enable are applied. The asynchronous active-low reset is released to the logic through a two-flop reset synchronizer.

Top module: `pin_group_irq`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Register map: control word at 0x00 (bit 0 status, bit 1 merge mode, bit 2 trigger mode, bits 31:3 read zero), polarity for port 0 at 0x20 and port 1 at 0x24, enable for port 0 at 0x40 and port 1 at 0x44. Polarity and enable words read back what was written, and any other address reads zero.
- R3: Bit n of the polarity word of port p applies to pin `pins_i[p*32+n]`. A 1 makes the pin active when high, and a 0 makes it active when low.
- R4: A pin whose enable bit is 0 has no effect on the group condition.
- R5: With merge bit 0, the group condition is true when at least one enabled pin is active.
- R6: With merge bit 1, the group condition is true only when every enabled pin is active. With no pin enabled it is false.
- R7: With trigger bit 0 (edge), status is set on a clock where the group condition goes from false to true. It then stays set until software clears it, even after the condition falls.
- R8: With trigger bit 1 (level), status is set on every clock while the group condition is true, so a clear takes hold only once the condition is false.
- R9: A write to 0x00 with data bit 0 at 1 clears the status. With data bit 0 at 0, the status is left unchanged.
- R10: When a hardware set and a software clear fall on the same clock, the status ends up set.
- R11: `irq_o` follows the status bit. A pin change driven between clocks shows on `irq_o` after the third rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 64 | Raw pin levels, port p pin n at bit p*32+n |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Grouped interrupt request |

## Verification
On every cycle the assertions check how the status moves: a hardware set always leaves it high, a clear without a set always drops it, nothing else changes it, level mode with a true condition keeps it high, and an all-pins merge with an empty selection never yields a true condition. Only the bench's scenarios can show the register map and readback, the per-pin mapping of polarity and enable, the three-edge latency from pin to interrupt, the hold of an edge-latched request after the pins fall, and the outcome of a set that meets a clear on the same clock.

// File: rtl/gpig_pkg.sv
package gpig_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFS_CTRL     = 8'h00;
  localparam logic [AW-1:0] OFS_POL_BASE = 8'h20;
  localparam logic [AW-1:0] OFS_ENA_BASE = 8'h40;
  localparam int unsigned   WORD_STRIDE  = 4;

  localparam int unsigned BIT_STAT = 0;
  localparam int unsigned BIT_MERGE = 1;
  localparam int unsigned BIT_TRIG = 2;

  typedef enum logic {MERGE_ANY = 1'b0, MERGE_ALL = 1'b1} merge_e;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

  typedef struct packed {
    trig_e  trig;
    merge_e merge;
  } mode_t;
endpackage

// File: rtl/gpig_rst_sync.sv
module gpig_rst_sync (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpig_sync.sv
module gpig_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/gpig_regs.sv
module gpig_regs
  import gpig_pkg::*;
#(
  parameter int unsigned NPORT = 2,
  parameter int unsigned PW    = 32
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                stat_i,
  output logic [DW-1:0]       rdata_o,
  output mode_t               mode_o,
  output logic [NPORT*PW-1:0] pol_o,
  output logic [NPORT*PW-1:0] ena_o,
  output logic                clr_o
);
  mode_t mode_q, mode_d;
  logic  ctrl_hit;

  logic [PW-1:0] pol_q [NPORT];
  logic [PW-1:0] ena_q [NPORT];
  logic [NPORT-1:0] pol_hit;
  logic [NPORT-1:0] ena_hit;

  assign ctrl_hit = (addr_i == OFS_CTRL);
  assign clr_o    = we_i && ctrl_hit && wdata_i[BIT_STAT];

  always_comb begin
    mode_d = mode_q;
    if (we_i && ctrl_hit) begin
      mode_d.merge = merge_e'(wdata_i[BIT_MERGE]);
      mode_d.trig  = trig_e'(wdata_i[BIT_TRIG]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '{trig: TRIG_EDGE, merge: MERGE_ANY};
    else         mode_q <= mode_d;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [AW-1:0] POL_ADR = OFS_POL_BASE + AW'(p * WORD_STRIDE);
    localparam logic [AW-1:0] ENA_ADR = OFS_ENA_BASE + AW'(p * WORD_STRIDE);
    logic [PW-1:0] pol_d;
    logic [PW-1:0] ena_d;

    assign pol_hit[p] = (addr_i == POL_ADR);
    assign ena_hit[p] = (addr_i == ENA_ADR);

    always_comb begin
      pol_d = pol_q[p];
      ena_d = ena_q[p];
      if (we_i && pol_hit[p]) pol_d = wdata_i[PW-1:0];
      if (we_i && ena_hit[p]) ena_d = wdata_i[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_q[p] <= '0;
        ena_q[p] <= '0;
      end else begin
        pol_q[p] <= pol_d;
        ena_q[p] <= ena_d;
      end
    end

    assign pol_o[p*PW +: PW] = pol_q[p];
    assign ena_o[p*PW +: PW] = ena_q[p];
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[BIT_STAT]  = stat_i;
      rdata_o[BIT_MERGE] = mode_q.merge;
      rdata_o[BIT_TRIG]  = mode_q.trig;
    end
    for (int p = 0; p < NPORT; p++) begin
      if (pol_hit[p]) rdata_o[PW-1:0] = pol_q[p];
      if (ena_hit[p]) rdata_o[PW-1:0] = ena_q[p];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gpig_combine.sv
module gpig_combine
  import gpig_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] ena_i,
  input  merge_e       merge_i,
  output logic         cond_o
);
  logic [N-1:0] match;
  logic         any_hit;
  logic         all_hit;

  assign match   = ~(pins_i ^ pol_i) & ena_i;
  assign any_hit = |match;
  assign all_hit = (match == ena_i) && (|ena_i);

  always_comb begin
    case (merge_i)
      MERGE_ALL: cond_o = all_hit;
      default:   cond_o = any_hit;
    endcase
  end
endmodule

// File: rtl/gpig_status.sv
module gpig_status
  import gpig_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  cond_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  set_o,
  output logic  stat_o
);
  logic cond_prev_q;
  logic stat_q, stat_d;

  always_comb begin
    case (trig_i)
      TRIG_LEVEL: set_o = cond_i;
      default:    set_o = cond_i && !cond_prev_q;
    endcase
    stat_d = set_o || (stat_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_prev_q <= 1'b0;
      stat_q      <= 1'b0;
    end else begin
      cond_prev_q <= cond_i;
      stat_q      <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/pin_group_irq.sv
module pin_group_irq
  import gpig_pkg::*;
#(
  parameter int unsigned NPORT = 2,
  parameter int unsigned PW    = 32,
  localparam int unsigned NPIN = NPORT * PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  logic            rst_sync_n;
  logic [NPIN-1:0] pins_s;
  logic [NPIN-1:0] pol_w;
  logic [NPIN-1:0] ena_w;
  mode_t           mode_w;
  logic            clr_w;
  logic            cond_w;
  logic            set_w;
  logic            stat_w;

  gpig_rst_sync u_rst (
    .clk     (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  gpig_sync #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (pins_i),
    .q_o    (pins_s)
  );

  gpig_regs #(.NPORT(NPORT), .PW(PW)) u_regs (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .wdata_i (bus_wdata),
    .stat_i  (stat_w),
    .rdata_o (bus_rdata),
    .mode_o  (mode_w),
    .pol_o   (pol_w),
    .ena_o   (ena_w),
    .clr_o   (clr_w)
  );

  gpig_combine #(.N(NPIN)) u_comb (
    .pins_i  (pins_s),
    .pol_i   (pol_w),
    .ena_i   (ena_w),
    .merge_i (mode_w.merge),
    .cond_o  (cond_w)
  );

  gpig_status u_stat (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .cond_i (cond_w),
    .trig_i (mode_w.trig),
    .clr_i  (clr_w),
    .set_o  (set_w),
    .stat_o (stat_w)
  );

  assign irq_o = stat_w;
endmodule

// File: rtl/gpig_chk.sv
module gpig_chk #(
  parameter int unsigned NPIN = 64
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            irq,
  input logic            set,
  input logic            clr,
  input logic            cond,
  input logic            level_mode,
  input logic            all_mode,
  input logic [NPIN-1:0] ena
);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> irq);

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && !set) |=> !irq);

  // R7
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq && !clr) |=> irq);

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!irq && !set) |=> !irq);

  // R8
  level_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (level_mode && cond) |=> irq);

  // R6
  empty_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (all_mode && (ena == '0)) |-> !cond);
endmodule

bind pin_group_irq gpig_chk #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .irq        (irq_o),
  .set        (set_w),
  .clr        (clr_w),
  .cond       (cond_w),
  .level_mode (mode_w.trig == gpig_pkg::TRIG_LEVEL),
  .all_mode   (mode_w.merge == gpig_pkg::MERGE_ALL),
  .ena        (ena_w)
);

// File: tb/pin_group_irq_tb_top.sv
module pin_group_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pins;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_group_irq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 pol0", 8'h20, 32'h0);
    rd_chk("R1 pol1", 8'h24, 32'h0);
    rd_chk("R1 ena0", 8'h40, 32'h0);
    rd_chk("R1 ena1", 8'h44, 32'h0);
  endtask

  task automatic t_regmap;
    wr(8'h20, 32'hA5A5_0001);
    wr(8'h24, 32'h1234_5678);
    wr(8'h40, 32'h0F0F_F0F0);
    wr(8'h44, 32'h8000_0001);
    rd_chk("R2 pol0", 8'h20, 32'hA5A5_0001);
    rd_chk("R2 pol1", 8'h24, 32'h1234_5678);
    rd_chk("R2 ena0", 8'h40, 32'h0F0F_F0F0);
    rd_chk("R2 ena1", 8'h44, 32'h8000_0001);
    rd_chk("R2 unmapped", 8'h10, 32'h0);
    rd_chk("R2 unmapped", 8'h48, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl mode bits", 8'h00, 32'h0000_0006);
    wr(8'h00, 32'h1);
    settle(4);
    rd_chk("R2 ctrl back", 8'h00, 32'h0);
  endtask

  task automatic t_or_edge;
    @(negedge clk); pins = 64'h0; pins[32] = 1'b1;
    wr(8'h20, 32'h0000_0008);
    wr(8'h24, 32'h0);
    wr(8'h40, 32'h0000_0008);
    wr(8'h44, 32'h0000_0001);
    settle(4);
    chk("R5 idle", {31'b0, irq}, 32'h0);
    // latency: drive at a falling edge, expect rise after third rising edge
    @(negedge clk); pins[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 not before third edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 R3 R5 active-high pin", {31'b0, irq}, 32'h1);
    @(negedge clk); pins[3] = 1'b0;
    settle(4);
    chk("R7 held after fall", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);
    settle(1);
    chk("R9 write zero keeps", {31'b0, irq}, 32'h1);
    rd_chk("R9 status readable", 8'h00, 32'h1);
    wr(8'h00, 32'h1);
    chk("R9 write one clears", {31'b0, irq}, 32'h0);
    @(negedge clk); pins[32] = 1'b0;
    settle(4);
    chk("R3 active-low pin", {31'b0, irq}, 32'h1);
    @(negedge clk); pins[32] = 1'b1;
    settle(4);
    wr(8'h00, 32'h1);
    @(negedge clk); pins[5] = 1'b1; pins[40] = 1'b0;
    settle(5);
    chk("R4 disabled pins", {31'b0, irq}, 32'h0);
    @(negedge clk); pins[5] = 1'b0; pins[40] = 1'b0;
  endtask

  task automatic t_and;
    wr(8'h00, 32'h3);
    settle(4);
    wr(8'h00, 32'h3);
    @(negedge clk); pins[3] = 1'b1;
    settle(5);
    chk("R6 partial not enough", {31'b0, irq}, 32'h0);
    @(negedge clk); pins[32] = 1'b0;
    settle(5);
    chk("R6 all active", {31'b0, irq}, 32'h1);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h00, 32'h3);
    @(negedge clk); pins = 64'hFFFF_FFFF_FFFF_FFFF;
    settle(3);
    @(negedge clk); pins = 64'h0;
    settle(5);
    chk("R6 empty selection", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_level;
    wr(8'h40, 32'h0000_0008);
    wr(8'h20, 32'h0000_0008);
    wr(8'h00, 32'h5);
    settle(2);
    chk("R8 idle", {31'b0, irq}, 32'h0);
    @(negedge clk); pins[3] = 1'b1;
    settle(5);
    chk("R8 level set", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h5);
    settle(1);
    chk("R8 clear while true", {31'b0, irq}, 32'h1);
    @(negedge clk); pins[3] = 1'b0;
    settle(5);
    chk("R8 latched after fall", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h5);
    chk("R8 clear once false", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    wr(8'h00, 32'h1);
    settle(4);
    @(negedge clk); pins[3] = 1'b1;
    settle(5);
    @(negedge clk); pins[3] = 1'b0;
    settle(5);
    chk("R10 pre-set", {31'b0, irq}, 32'h1);
    @(negedge clk); pins[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h00; wdata = 32'h1; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
    chk("R10 set beats clear", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h1);
    chk("R10 later clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; addr = '0; we = 1'b0; wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    t_reset();
    t_regmap();
    t_or_edge();
    t_and();
    t_level();
    t_collide();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule